// File: doc/BRIEF.md
# Auxiliary Memory Bank-Switch Controller

This block holds the memory-mapping flags of an 8-bit machine that has two 64 KB RAM banks, a main bank and an auxiliary bank. The CPU changes the flags by touching addresses in the $C000–$C0FF I/O page, and reads a flag back as bit 7 of a status byte. For every address below $C000 the block drives one bank select for reads and a separate one for writes. These two selects can differ, so a read-modify-write can fetch from one bank and store into the other.

Two groups of flags control the mapping. The first group gives each of these its own flag: the zero page and stack, reads, and writes. The second group is the display page flag together with the 80-column store and hi-res modes. When 80-column store is on, the display flags take the text page from the read and write flags. When hi-res is also on, they take the hi-res page as well. The ROM overlay flags are only held here. The one internal-ROM flag that has no status address is brought out on a port of its own.

Top module: `auxbank_ctl`

## Requirements
- R1: After reset every flag is clear except the text-mode flag. A status read of $C01A returns 8'h80, and a status read of $C018 returns 8'h00.
- R2: On a valid write to $C000–$C00B, the even address of each pair clears a flag and the odd address sets it. The pairs in order are 80-column store, read-aux, write-aux, internal slot ROM, alternate zero page and slot-3 ROM. A read in $C000–$C00F changes no flag.
- R3: A valid access to $C050–$C057, read or write, clears (even address) or sets (odd address) one display flag. The pairs in order are text, mixed, page 2 and hi-res.
- R4: A valid read returns the flag in bit 7 of rd_data, with bits 6–0 zero. The addresses are $C013 read-aux, $C014 write-aux, $C015 internal slot ROM, $C016 alternate zero page, $C017 slot-3 ROM, $C018 80-column store, $C01A text, $C01B mixed, $C01C page 2 and $C01D hi-res. Every other access returns 8'h00.
- R5: For $0000–$01FF the alternate zero page flag alone picks the bank, for reads and writes alike.
- R6: For $0200–$BFFF, outside the overrides, the read-aux flag picks the read bank and the write-aux flag picks the write bank, each independent of the other.
- R7: With 80-column store set, $0400–$07FF uses the auxiliary bank for both reads and writes when page 2 is set, and the main bank when it is clear.
- R8: With 80-column store and hi-res both set, $2000–$3FFF follows page 2 as in R7. With hi-res clear, that range follows R6.
- R9: For addresses $C000 and above, both rd_bank and wr_bank are 2'b00. Below $C000 each select is 2'b01 for the main bank or 2'b10 for the auxiliary bank.
- R10: A valid access to $CFFF clears c8_rom_int. A valid access to $C300–$C3FF while the slot-3 ROM flag is clear sets it.
- R11: A flag changes on the clock edge that ends its qualifying access. The bank selects and status are combinational, so the very next access sees the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_valid | input | 1 | Access qualifier |
| rd_data | output | 8 | Status byte for flag reads |
| rd_bank | output | 2 | Read bank select: 01 main, 10 aux, 00 none |
| wr_bank | output | 2 | Write bank select: 01 main, 10 aux, 00 none |
| c8_rom_int | output | 1 | Internal $C800 ROM flag |

## Verification
The properties assume that cpu_addr, cpu_we and cpu_valid are stable from one falling clock edge to the next, so each rising edge sees exactly one access. The bench drives every input only at falling edges to meet this. It samples the outputs shortly after the inputs settle, which is before the edge that commits the access. As a result, each sample reflects the flags left by the earlier accesses. No switch write is ever issued while reset is asserted.

// File: rtl/auxbank_pkg.sv
package auxbank_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    localparam logic [1:0] BANK_NONE = 2'b00;
    localparam logic [1:0] BANK_MAIN = 2'b01;
    localparam logic [1:0] BANK_AUX  = 2'b10;

    typedef struct packed {
        logic store80;
        logic rd_aux;
        logic wr_aux;
        logic int_cx;
        logic alt_zp;
        logic slot_c3;
        logic text;
        logic mixed;
        logic page2;
        logic hires;
        logic int_c8;
    } sw_t;

    localparam sw_t SW_RESET = '{store80: 1'b0, rd_aux: 1'b0, wr_aux: 1'b0,
                                 int_cx: 1'b0, alt_zp: 1'b0, slot_c3: 1'b0,
                                 text: 1'b1, mixed: 1'b0, page2: 1'b0,
                                 hires: 1'b0, int_c8: 1'b0};

endpackage

// File: rtl/auxbank_sw_next.sv
module auxbank_sw_next
    import auxbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              valid,
    input  sw_t               sw_q,
    output sw_t               sw_d
);

    always_comb begin
        sw_d = sw_q;
        if (valid) begin
            // memory-mapping pairs: writes only
            if (we && addr[15:4] == 12'hC00) begin
                case (addr[3:1])
                    3'd0: sw_d.store80 = addr[0];
                    3'd1: sw_d.rd_aux  = addr[0];
                    3'd2: sw_d.wr_aux  = addr[0];
                    3'd3: sw_d.int_cx  = addr[0];
                    3'd4: sw_d.alt_zp  = addr[0];
                    3'd5: sw_d.slot_c3 = addr[0];
                    default: ;
                endcase
            end
            // display pairs: any access
            if (addr[15:3] == 13'h180A) begin
                case (addr[2:1])
                    2'd0: sw_d.text  = addr[0];
                    2'd1: sw_d.mixed = addr[0];
                    2'd2: sw_d.page2 = addr[0];
                    2'd3: sw_d.hires = addr[0];
                    default: ;
                endcase
            end
            if (addr == 16'hCFFF) begin
                sw_d.int_c8 = 1'b0;
            end else if (addr[15:8] == 8'hC3 && !sw_q.slot_c3) begin
                sw_d.int_c8 = 1'b1;
            end
        end
    end

endmodule

// File: rtl/auxbank_map.sv
module auxbank_map
    import auxbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  sw_t               sw_q,
    output logic [1:0]        rd_bank,
    output logic [1:0]        wr_bank
);

    logic is_io, is_zp, is_text, is_hires;
    logic [1:0] base_aux;
    logic [1:0] sel_aux;
    logic [1:0] sel_bank [2];

    always_comb begin
        is_io    = addr[15:14] == 2'b11;
        is_zp    = addr[15:9] == 7'd0;
        is_text  = addr[15:10] == 6'b000001;
        is_hires = addr[15:13] == 3'b001;
        base_aux = {sw_q.wr_aux, sw_q.rd_aux};
    end

    for (genvar g = 0; g < 2; g++) begin : g_dir
        always_comb begin
            if (is_zp)
                sel_aux[g] = sw_q.alt_zp;
            else if (sw_q.store80 && is_text)
                sel_aux[g] = sw_q.page2;
            else if (sw_q.store80 && sw_q.hires && is_hires)
                sel_aux[g] = sw_q.page2;
            else
                sel_aux[g] = base_aux[g];
            if (is_io)
                sel_bank[g] = BANK_NONE;
            else
                sel_bank[g] = sel_aux[g] ? BANK_AUX : BANK_MAIN;
        end
    end

    assign rd_bank = sel_bank[0];
    assign wr_bank = sel_bank[1];

endmodule

// File: rtl/auxbank_status.sv
module auxbank_status
    import auxbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              valid,
    input  sw_t               sw_q,
    output logic [DATA_W-1:0] rd_data
);

    logic flag_bit;

    always_comb begin
        case (addr[3:0])
            4'h3: flag_bit = sw_q.rd_aux;
            4'h4: flag_bit = sw_q.wr_aux;
            4'h5: flag_bit = sw_q.int_cx;
            4'h6: flag_bit = sw_q.alt_zp;
            4'h7: flag_bit = sw_q.slot_c3;
            4'h8: flag_bit = sw_q.store80;
            4'hA: flag_bit = sw_q.text;
            4'hB: flag_bit = sw_q.mixed;
            4'hC: flag_bit = sw_q.page2;
            4'hD: flag_bit = sw_q.hires;
            default: flag_bit = 1'b0;
        endcase
        rd_data = '0;
        if (valid && !we && addr[15:4] == 12'hC01)
            rd_data[DATA_W-1] = flag_bit;
    end

endmodule

// File: rtl/auxbank_ctl.sv
module auxbank_ctl
    import auxbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_bank,
    output logic [1:0]        wr_bank,
    output logic              c8_rom_int
);

    sw_t sw_d, sw_q;

    auxbank_sw_next u_next (
        .addr  (cpu_addr),
        .we    (cpu_we),
        .valid (cpu_valid),
        .sw_q  (sw_q),
        .sw_d  (sw_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= SW_RESET;
        else        sw_q <= sw_d;
    end

    auxbank_map u_map (
        .addr    (cpu_addr),
        .sw_q    (sw_q),
        .rd_bank (rd_bank),
        .wr_bank (wr_bank)
    );

    auxbank_status u_stat (
        .addr    (cpu_addr),
        .we      (cpu_we),
        .valid   (cpu_valid),
        .sw_q    (sw_q),
        .rd_data (rd_data)
    );

    assign c8_rom_int = sw_q.int_c8;

endmodule

// File: rtl/auxbank_ctl_chk.sv
module auxbank_ctl_chk
    import auxbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_we,
    input logic              cpu_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        rd_bank,
    input logic [1:0]        wr_bank,
    input sw_t               sw_q
);

    p_io_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:14] == 2'b11 |-> (rd_bank == BANK_NONE && wr_bank == BANK_NONE));

    p_ram_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:14] != 2'b11 |-> ($countones(rd_bank) == 1 && $countones(wr_bank) == 1));

    p_zp_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr < 16'h0200 |-> rd_bank == wr_bank);

    p_text_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q.store80 && cpu_addr[15:10] == 6'b000001) |-> rd_bank == wr_bank);

    p_read_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_we && cpu_addr[15:4] == 12'hC00) |=> sw_q == $past(sw_q));

    p_wr_aux_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_we && cpu_addr == 16'hC005) |=> sw_q.wr_aux);

    p_status_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == 7'd0);

    p_c8_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_addr == 16'hCFFF) |=> !sw_q.int_c8);

endmodule

bind auxbank_ctl auxbank_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .cpu_valid (cpu_valid),
    .rd_data   (rd_data),
    .rd_bank   (rd_bank),
    .wr_bank   (wr_bank),
    .sw_q      (sw_q)
);

// File: tb/auxbank_ctl_tb.sv
module auxbank_ctl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_we = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [7:0]  rd_data;
    logic [1:0]  rd_bank, wr_bank;
    logic        c8_rom_int;

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  rd;
        logic [1:0]  wr;
        logic [7:0]  data;
        logic        c8;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    event  ev_sample;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    auxbank_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_we     (cpu_we),
        .cpu_valid  (cpu_valid),
        .rd_data    (rd_data),
        .rd_bank    (rd_bank),
        .wr_bank    (wr_bank),
        .c8_rom_int (c8_rom_int)
    );

    // monitor: pops expectation and compares against the outputs
    initial begin
        forever begin
            @(ev_sample);
            #1;
            while (exp_q.size() > 0) begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                n_chk++;
                if (rd_bank !== e.rd || wr_bank !== e.wr || rd_data !== e.data
                    || c8_rom_int !== e.c8) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual rd=%b wr=%b data=%h c8=%b expected rd=%b wr=%b data=%h c8=%b",
                             r, e.addr, rd_bank, wr_bank, rd_data, c8_rom_int,
                             e.rd, e.wr, e.data, e.c8);
                end
            end
        end
    end

    task automatic acc(input logic [15:0] a, input logic w);
        @(negedge clk);
        cpu_addr  = a;
        cpu_we    = w;
        cpu_valid = 1'b1;
    endtask

    task automatic probe(input logic [15:0] a, input logic w, input logic [1:0] er,
                         input logic [1:0] ew, input logic [7:0] ed, input logic ec8,
                         input string req);
        exp_t e;
        @(negedge clk);
        cpu_addr  = a;
        cpu_we    = w;
        cpu_valid = 1'b1;
        e = '{addr: a, rd: er, wr: ew, data: ed, c8: ec8};
        exp_q.push_back(e);
        req_q.push_back(req);
        -> ev_sample;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        probe(16'hC01A, 0, 2'b00, 2'b00, 8'h80, 0, "R1");
        probe(16'hC018, 0, 2'b00, 2'b00, 8'h00, 0, "R1");
        probe(16'h0300, 0, 2'b01, 2'b01, 8'h00, 0, "R1");
        // R6/R11 write-aux alone: read main, write aux
        acc(16'hC005, 1);
        probe(16'h0300, 0, 2'b01, 2'b10, 8'h00, 0, "R6");
        probe(16'hC014, 0, 2'b00, 2'b00, 8'h80, 0, "R4");
        // R2 read of switch address ignored
        acc(16'hC004, 0);
        probe(16'hC014, 0, 2'b00, 2'b00, 8'h80, 0, "R2");
        acc(16'hC004, 1);
        probe(16'hC014, 0, 2'b00, 2'b00, 8'h00, 0, "R2");
        // read-aux, zero page independent
        acc(16'hC003, 1);
        probe(16'h1000, 0, 2'b10, 2'b01, 8'h00, 0, "R6");
        probe(16'h0100, 0, 2'b01, 2'b01, 8'h00, 0, "R5");
        acc(16'hC009, 1);
        probe(16'h00FF, 1, 2'b10, 2'b10, 8'h00, 0, "R5");
        probe(16'hC016, 0, 2'b00, 2'b00, 8'h80, 0, "R4");
        acc(16'hC008, 1);
        // 80-column store overrides
        acc(16'hC001, 1);
        probe(16'h0400, 0, 2'b01, 2'b01, 8'h00, 0, "R7");
        probe(16'h2000, 0, 2'b10, 2'b01, 8'h00, 0, "R8");
        acc(16'hC055, 0);
        probe(16'h07FF, 0, 2'b10, 2'b10, 8'h00, 0, "R7");
        probe(16'hC01C, 0, 2'b00, 2'b00, 8'h80, 0, "R3");
        acc(16'hC057, 1);
        probe(16'h3FFF, 0, 2'b10, 2'b10, 8'h00, 0, "R8");
        probe(16'h4000, 0, 2'b10, 2'b01, 8'h00, 0, "R8");
        probe(16'hC019, 0, 2'b00, 2'b00, 8'h00, 0, "R4");
        acc(16'hC054, 0);
        probe(16'h2000, 0, 2'b01, 2'b01, 8'h00, 0, "R8");
        probe(16'hC01D, 0, 2'b00, 2'b00, 8'h80, 0, "R3");
        // R9 I/O and above unmapped
        probe(16'hC000, 0, 2'b00, 2'b00, 8'h00, 0, "R9");
        probe(16'hFFFF, 1, 2'b00, 2'b00, 8'h00, 0, "R9");
        probe(16'hC018, 0, 2'b00, 2'b00, 8'h80, 0, "R2");
        // R10 internal C8 ROM flag
        probe(16'hC300, 0, 2'b00, 2'b00, 8'h00, 0, "R10");
        probe(16'h0300, 0, 2'b10, 2'b01, 8'h00, 1, "R10");
        acc(16'hCFFF, 0);
        probe(16'h0300, 0, 2'b10, 2'b01, 8'h00, 0, "R10");
        acc(16'hC00B, 1);
        acc(16'hC300, 0);
        probe(16'h0300, 0, 2'b10, 2'b01, 8'h00, 0, "R10");
        probe(16'hC017, 0, 2'b00, 2'b00, 8'h80, 0, "R4");
        // R3 remaining display pairs
        acc(16'hC053, 1);
        probe(16'hC01B, 0, 2'b00, 2'b00, 8'h80, 0, "R3");
        acc(16'hC050, 1);
        probe(16'hC01A, 0, 2'b00, 2'b00, 8'h00, 0, "R3");
        acc(16'hC007, 1);
        probe(16'hC015, 0, 2'b00, 2'b00, 8'h80, 0, "R2");
        @(negedge clk);
        cpu_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule